// File: doc/BRIEF.md
# Packed Program Counter and Condition Flags Register

This block holds one 32-bit architectural word that carries two things at once: a word-aligned program counter for a 64 MB address space, and the four arithmetic condition flags in the top nibble. The PC occupies bits 25:2 and the flags occupy bits 31:28. The four remaining bits (27:26 and 1:0) are control bits that only privileged code may see or change.

The register has three update paths:
- **Sequential step:** advances the PC by one word.
- **Branch load:** replaces the PC field.
- **Flag update:** replaces the flag nibble.

A whole-word write path is also provided for moving a general-purpose value into the register. Each path touches only its own field, so several of them can act in the same cycle.

There is a single read port with two views, selected by operand position. As the first source of a binary operation, the register yields only its PC bits, so PC-relative arithmetic sees a clean address. In every other read context it yields the complete word, flags included. A privilege input decides whether the control bits appear on reads and whether word writes may change them.

Top module: `pcf_reg`

## Requirements
- R1: After reset, and after any later reset, the whole register is zero.
- R2: A flag update loads `flag_i` into bits 31:28, with `flag_i[3]` going to bit 31 (N), then Z, C, and V at bit 28. Bits 27:0 are unchanged.
- R3: A step adds 4 to the byte address held in bits 25:2. The address wraps from 0x03FFFFFC to 0, and bits 31:26 and 1:0 are untouched.
- R4: A branch load places `jump_pc_i` (a word index) into bits 25:2 and leaves all other bits unchanged.
- R5: When a branch load and a step are requested together, the branch target wins.
- R6: With `rd_first_i` = 1, `rd_data_o` equals the register ANDed with 0x03FFFFFC, in either privilege mode.
- R7: With `rd_first_i` = 0 and `priv_i` = 1, `rd_data_o` is the complete 32-bit register.
- R8: With `rd_first_i` = 0 and `priv_i` = 0, bits 27:26 and 1:0 of `rd_data_o` read as zero, and the other bits are shown unchanged.
- R9: A word write with `priv_i` = 0 updates bits 31:28 and 25:2 from `wr_data_i` and leaves bits 27:26 and 1:0 unchanged.
- R10: A word write with `priv_i` = 1 loads all 32 bits of `wr_data_i`.
- R11: A word write overrides a flag update, a branch load, and a step requested in the same cycle.
- R12: A flag update and a step (or a branch load) in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| step_i | input | 1 | Advance the PC by one word |
| jump_i | input | 1 | Load the PC field from `jump_pc_i` |
| jump_pc_i | input | 24 | Branch target as a word index |
| flag_we_i | input | 1 | Load the flag nibble |
| flag_i | input | 4 | New flags: N, Z, C, V from bit 3 down |
| wr_en_i | input | 1 | Whole-word write |
| wr_data_i | input | 32 | Word write data |
| rd_first_i | input | 1 | 1 = read as first operand (masked view) |
| rd_data_o | output | 32 | Read data in the selected view |

## Verification
Two kinds of same-cycle collision are exercised:
- **Flag update with a PC change.** A flag update arrives in the same cycle as a step or branch load. The check is that both fields change, since they must merge rather than compete.
- **Word write with other updates.** A word write lands in the same cycle as a flag update, a branch load, and a step. The check is that only the word-write value survives, and that in user mode the control bits still keep their old value.

Each collision is provoked by a single vector that raises all of the enables together. The result is judged through the complete privileged view one cycle later.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
    localparam int WORD_W    = 32;
    localparam int FLAG_W    = 4;
    localparam int PC_LSB    = 2;
    localparam int PC_W      = 24;
    localparam int CTRL_HI_W = WORD_W - FLAG_W - PC_W - PC_LSB;

    localparam logic [WORD_W-1:0] PC_MASK =
        ((WORD_W'(1) << PC_W) - WORD_W'(1)) << PC_LSB;
    localparam logic [WORD_W-1:0] FLAG_MASK =
        ((WORD_W'(1) << FLAG_W) - WORD_W'(1)) << (WORD_W - FLAG_W);
    localparam logic [WORD_W-1:0] CTRL_MASK = ~(PC_MASK | FLAG_MASK);

    typedef struct packed {
        logic [FLAG_W-1:0]    flags;
        logic [CTRL_HI_W-1:0] ctrl_hi;
        logic [PC_W-1:0]      pc;
        logic [PC_LSB-1:0]    ctrl_lo;
    } psr_word_t;
endpackage

// File: rtl/pcf_pc_path.sv
module pcf_pc_path
    import pcf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            jump,
    input  logic [PC_W-1:0] jump_pc,
    input  logic            step,
    input  logic [PC_W-1:0] pc_q,
    output logic [PC_W-1:0] pc_d
);
    always_comb begin
        pc_d = pc_q;
        if (wr_en)
            pc_d = wr_pc;
        else if (jump)
            pc_d = jump_pc;
        else if (step)
            pc_d = pc_q + PC_W'(1);
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !jump && !wr_en) |=> (pc_q == $past(pc_q) + PC_W'(1))); // R3
    AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (jump && !wr_en) |=> (pc_q == $past(jump_pc))); // R5
    AST_PC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pc_q == $past(wr_pc))); // R11
endmodule

// File: rtl/pcf_flag_path.sv
module pcf_flag_path
    import pcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic [FLAG_W-1:0] flags_q,
    output logic [FLAG_W-1:0] flags_d
);
    always_comb begin
        flags_d = flags_q;
        if (wr_en)
            flags_d = wr_flags;
        else if (flag_we)
            flags_d = flag_in;
    end

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !wr_en) |=> (flags_q == $past(flag_in))); // R12
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && !wr_en) |=> $stable(flags_q)); // R2
endmodule

// File: rtl/pcf_ctrl_path.sv
module pcf_ctrl_path
    import pcf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 priv,
    input  logic [CTRL_HI_W-1:0] wr_hi,
    input  logic [PC_LSB-1:0]    wr_lo,
    input  logic [CTRL_HI_W-1:0] hi_q,
    input  logic [PC_LSB-1:0]    lo_q,
    output logic [CTRL_HI_W-1:0] hi_d,
    output logic [PC_LSB-1:0]    lo_d
);
    logic granted;

    always_comb begin
        granted = wr_en && priv;
        hi_d    = granted ? wr_hi : hi_q;
        lo_d    = granted ? wr_lo : lo_q;
    end

    AST_USER_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv || !wr_en) |=> ($stable(hi_q) && $stable(lo_q))); // R9
    AST_PRIV_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (priv && wr_en) |=> (hi_q == $past(wr_hi) && lo_q == $past(wr_lo))); // R10
endmodule

// File: rtl/pcf_read_view.sv
module pcf_read_view
    import pcf_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              priv,
    input  logic              first,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] full_view;
    logic [WORD_W-1:0] opnd_view;

    always_comb begin
        full_view = priv ? word : (word & ~CTRL_MASK);
        opnd_view = word & PC_MASK;
        rd_data   = first ? opnd_view : full_view;
    end

    always_comb begin
        if (first)
            AST_OPND_CLEAN: assert ((rd_data & ~PC_MASK) == '0); // R6
        if (!first && !priv)
            AST_USER_HIDE: assert ((rd_data & CTRL_MASK) == '0); // R8
    end
endmodule

// File: rtl/pcf_reg.sv
module pcf_reg
    import pcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic              step_i,
    input  logic              jump_i,
    input  logic [PC_W-1:0]   jump_pc_i,
    input  logic              flag_we_i,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_first_i,
    output logic [WORD_W-1:0] rd_data_o
);
    psr_word_t reg_q;
    psr_word_t reg_d;
    psr_word_t wr_word;

    logic [PC_W-1:0]      pc_d;
    logic [FLAG_W-1:0]    flags_d;
    logic [CTRL_HI_W-1:0] hi_d;
    logic [PC_LSB-1:0]    lo_d;

    assign wr_word = psr_word_t'(wr_data_i);

    pcf_pc_path u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_pc   (wr_word.pc),
        .jump    (jump_i),
        .jump_pc (jump_pc_i),
        .step    (step_i),
        .pc_q    (reg_q.pc),
        .pc_d    (pc_d)
    );

    pcf_flag_path u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_flags (wr_word.flags),
        .flag_we  (flag_we_i),
        .flag_in  (flag_i),
        .flags_q  (reg_q.flags),
        .flags_d  (flags_d)
    );

    pcf_ctrl_path u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en_i),
        .priv  (priv_i),
        .wr_hi (wr_word.ctrl_hi),
        .wr_lo (wr_word.ctrl_lo),
        .hi_q  (reg_q.ctrl_hi),
        .lo_q  (reg_q.ctrl_lo),
        .hi_d  (hi_d),
        .lo_d  (lo_d)
    );

    always_comb begin
        reg_d         = reg_q;
        reg_d.flags   = flags_d;
        reg_d.ctrl_hi = hi_d;
        reg_d.pc      = pc_d;
        reg_d.ctrl_lo = lo_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_q <= '0;
        else
            reg_q <= reg_d;
    end

    pcf_read_view u_view (
        .word    (reg_q),
        .priv    (priv_i),
        .first   (rd_first_i),
        .rd_data (rd_data_o)
    );

    AST_FULL_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i && !rd_first_i) |-> (rd_data_o == reg_q)); // R7
    AST_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && !wr_en_i && !jump_i && !step_i)
        |=> (reg_q[WORD_W-FLAG_W-1:0] == $past(reg_q[WORD_W-FLAG_W-1:0]))); // R2
endmodule

// File: tb/pcf_reg_bench.sv
module pcf_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_i = 1'b1;
    logic        step_i = 1'b0;
    logic        jump_i = 1'b0;
    logic [23:0] jump_pc_i = '0;
    logic        flag_we_i = 1'b0;
    logic [3:0]  flag_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        rd_first_i = 1'b0;
    logic [31:0] rd_data_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pcf_reg u_pcf_reg (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .step_i(step_i),
        .jump_i(jump_i), .jump_pc_i(jump_pc_i), .flag_we_i(flag_we_i),
        .flag_i(flag_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_first_i(rd_first_i), .rd_data_o(rd_data_o)
    );

    typedef struct packed {
        logic        priv;
        logic        step;
        logic        jump;
        logic [23:0] jpc;
        logic        fwe;
        logic [3:0]  fl;
        logic        we;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,24'h0,     1'b0,4'h0,1'b1,32'hFFFFFFFF,32'hFFFFFFFF,8'd10}, // R10
        '{1'b0,1'b0,1'b0,24'h0,     1'b0,4'h0,1'b1,32'h00000000,32'h0C000003,8'd9},  // R9
        '{1'b0,1'b1,1'b0,24'h0,     1'b0,4'h0,1'b0,32'h0,       32'h0C000007,8'd3},  // R3
        '{1'b0,1'b0,1'b0,24'h0,     1'b1,4'hA,1'b0,32'h0,       32'hAC000007,8'd2},  // R2
        '{1'b0,1'b0,1'b1,24'h8D159D,1'b0,4'h0,1'b0,32'h0,       32'hAE345677,8'd4},  // R4
        '{1'b0,1'b1,1'b1,24'h40,    1'b0,4'h0,1'b0,32'h0,       32'hAC000103,8'd5},  // R5
        '{1'b0,1'b1,1'b0,24'h0,     1'b1,4'h5,1'b0,32'h0,       32'h5C000107,8'd12}, // R12
        '{1'b1,1'b0,1'b0,24'h0,     1'b0,4'h0,1'b1,32'h03FFFFFC,32'h03FFFFFC,8'd10}, // R10
        '{1'b0,1'b1,1'b0,24'h0,     1'b0,4'h0,1'b0,32'h0,       32'h00000000,8'd3},  // R3 wrap
        '{1'b0,1'b0,1'b0,24'h0,     1'b1,4'h0,1'b1,32'hF3FFFFFF,32'hF3FFFFFC,8'd11}, // R11 user
        '{1'b1,1'b1,1'b1,24'h40,    1'b1,4'h0,1'b1,32'h0C000003,32'h0C000003,8'd11}  // R11 priv
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic idle();
        step_i = 0; jump_i = 0; flag_we_i = 0; wr_en_i = 0;
        priv_i = 1; rd_first_i = 0;
    endtask

    task automatic priv_write(input logic [31:0] v);
        @(negedge clk);
        priv_i = 1; wr_en_i = 1; wr_data_i = v;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        #1 check("R1 reset", rd_data_o, 32'h0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            priv_i = VECS[i].priv; step_i = VECS[i].step; jump_i = VECS[i].jump;
            jump_pc_i = VECS[i].jpc; flag_we_i = VECS[i].fwe; flag_i = VECS[i].fl;
            wr_en_i = VECS[i].we; wr_data_i = VECS[i].wd; rd_first_i = 0;
            @(negedge clk);
            idle();
            #1 check($sformatf("R%0d vector %0d", VECS[i].req, i), rd_data_o, VECS[i].exp);
        end

        // Read views (R6, R7, R8)
        priv_write(32'hF7654323);
        #1 check("R7 full privileged", rd_data_o, 32'hF7654323);
        rd_first_i = 1; #1 check("R6 operand privileged", rd_data_o, 32'h03654320);
        priv_i = 0;     #1 check("R6 operand user", rd_data_o, 32'h03654320);
        rd_first_i = 0; #1 check("R8 full user", rd_data_o, 32'hF3654320);
        priv_i = 1;     #1 check("R8 state intact", rd_data_o, 32'hF7654323);

        // R3: flags and ctrl bits around a wrap
        priv_write(32'h5FFFFFFF);
        @(negedge clk); step_i = 1;
        @(negedge clk); idle();
        #1 check("R3 wrap keeps flags and ctrl", rd_data_o, 32'h5C000003);

        // R1: reset mid-run
        @(negedge clk); rst_n = 0;
        #1 check("R1 async reset", rd_data_o, 32'h0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        #1 check("R1 after reset release", rd_data_o, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule